// File: doc/BRIEF.md
# Picture-in-Picture Display Window Timing

This block generates the display-side raster decisions for a picture-in-picture overlay. It counts pixels and lines from internal horizontal and vertical sync strobes and, for every pixel clock, classifies the current pixel into one of four regions: outside, background, main window, or sub window. The background rectangle is placed relative to sync by its own offsets. A fixed picture area is anchored at the background origin. The main and sub windows are placed inside that picture area by offsets measured from the background origin, and each is clipped to it. The height of the background and of the picture area depends on a line-standard select. The default line is 896 pixels. The background is 768 pixels wide and 238 or 286 lines tall. The picture area is 720 pixels wide and 228 or 276 lines tall.

A fast-blanking output tells the video switch to show inserted content. Two read-request strobes ask the frame-memory fetch logic for window pixels one clock before they are displayed. The request for a window is raised only for the pixels of that window that are actually visible, so a main-window pixel covered by the sub window is not fetched.

No data stream passes through the block. The read requests are timing strobes and have no ready input, because the raster cannot stall: the fetch logic must accept every request. All placement, size and standard inputs are shadowed and take effect together at the start of the next frame.

Top module: `pipwin_timing`

## Requirements
- R1: The pixel counter starts at 0 in the cycle after a cycle with `hsync_i` high, and the line counter advances by one at that point. If no sync arrives, the pixel counter wraps from LINE_PIX-1 to 0 by itself and the line counter advances. The line counter saturates at its maximum value.
- R2: A cycle with both `hsync_i` and `vsync_i` high makes the following cycle pixel 0 of line 0. `vsync_i` high without `hsync_i` has no effect.
- R3: A pixel (x,y) is inside the background when bg_x ≤ x < bg_x+BG_W and bg_y ≤ y < bg_y+L. L is BG_LINES_625 when `std625_i`=1 and BG_LINES_525 when it is 0. A background pixel that lies in no window has region code 1.
- R4: Relative to the background origin, a window pixel must lie within PIC_W pixels and PIC_LINES_625 or PIC_LINES_525 lines, according to the standard. Any window part outside that area shows as background (code 1) or as outside (code 0).
- R5: Main-window pixels have offsets from the background origin in [main_x, main_x+main_w) and [main_y, main_y+main_h), and have region code 2.
- R6: Sub-window pixels are defined in the same way from the sub inputs and have region code 3. Where the two windows overlap, the code is 3. Code 0 means outside the background.
- R7: `fblank_o` is 1 exactly when the region code is not 0.
- R8: `main_rd_o` (or `sub_rd_o`) is 1 at pixel x when pixel x+1 of the same line has region code 2 (or 3). Neither strobe is raised at pixel LINE_PIX-1.
- R9: All placement, size and standard inputs are captured only in a cycle with `hsync_i` and `vsync_i` both high. Changes at any other time have no effect on the outputs.
- R10: After reset, the line counter holds its maximum value and the captured settings are zero. Until the first frame start, the region is 0, fast blanking is low and no read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Internal line-start strobe |
| vsync_i | input | 1 | Internal frame-start strobe, valid with `hsync_i` |
| std625_i | input | 1 | 1 selects the 625-line heights, 0 the 525-line heights |
| bg_x_i | input | XW | Background horizontal offset from sync |
| bg_y_i | input | YW | Background vertical offset from sync |
| main_x_i | input | XW | Main window horizontal offset from background origin |
| main_y_i | input | YW | Main window vertical offset from background origin |
| main_w_i | input | XW | Main window width |
| main_h_i | input | YW | Main window height |
| sub_x_i | input | XW | Sub window horizontal offset from background origin |
| sub_y_i | input | YW | Sub window vertical offset from background origin |
| sub_w_i | input | XW | Sub window width |
| sub_h_i | input | YW | Sub window height |
| region_o | output | 2 | Region code of the current pixel: 0 outside, 1 background, 2 main, 3 sub |
| fblank_o | output | 1 | Fast blanking, high on inserted content |
| main_rd_o | output | 1 | Main window fetch request, one pixel ahead |
| sub_rd_o | output | 1 | Sub window fetch request, one pixel ahead |

## Verification
A corrupted pixel or line counter moves every region boundary. The error therefore appears in `region_o` at the next window or background edge, within one line for a horizontal fault and within one frame for a vertical fault. A bad shadow capture misplaces all rectangles in the first frame after it. An error in the lookahead decode shows up as a read strobe that is not followed by the matching region code on the next clock. The bench compares all four outputs on every pixel against an arithmetic model over several frames with differing placements. That comparison catches such faults at the first pixel where they become visible.

// File: rtl/pipwin_pkg.sv
package pipwin_pkg;

  typedef enum logic [1:0] {
    RG_OUT  = 2'd0,
    RG_BG   = 2'd1,
    RG_MAIN = 2'd2,
    RG_SUB  = 2'd3
  } region_t;

  // Half-open span test done at 32 bits so offset plus length cannot overflow.
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned org,
                                   input int unsigned len);
    return (pos >= org) && (pos < org + len);
  endfunction

endpackage

// File: rtl/pipwin_raster.sv
module pipwin_raster #(
  parameter int unsigned LINE_PIX = 896,
  parameter int unsigned XW       = 10,
  parameter int unsigned YW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_i,
  input  logic          vsync_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);

  localparam logic [XW-1:0] X_LAST = XW'(LINE_PIX - 1);

  logic [YW-1:0] y_inc;

  // Saturating line advance.
  assign y_inc = (y_o == '1) ? y_o : y_o + YW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '1;
    end else if (hsync_i) begin
      x_o <= '0;
      y_o <= vsync_i ? '0 : y_inc;
    end else if (x_o == X_LAST) begin
      x_o <= '0;
      y_o <= y_inc;
    end else begin
      x_o <= x_o + XW'(1);
    end
  end

endmodule

// File: rtl/pipwin_shadow.sv
module pipwin_shadow #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/pipwin_decode.sv
module pipwin_decode
  import pipwin_pkg::*;
#(
  parameter int unsigned BG_W          = 768,
  parameter int unsigned PIC_W         = 720,
  parameter int unsigned BG_LINES_525  = 238,
  parameter int unsigned BG_LINES_625  = 286,
  parameter int unsigned PIC_LINES_525 = 228,
  parameter int unsigned PIC_LINES_625 = 276,
  parameter int unsigned XW            = 10,
  parameter int unsigned YW            = 10
) (
  input  logic [XW:0]   x_i,
  input  logic [YW-1:0] y_i,
  input  logic          std_i,
  input  logic [XW-1:0] bgx_i,
  input  logic [YW-1:0] bgy_i,
  input  logic [XW-1:0] mx_i,
  input  logic [YW-1:0] my_i,
  input  logic [XW-1:0] mw_i,
  input  logic [YW-1:0] mh_i,
  input  logic [XW-1:0] sx_i,
  input  logic [YW-1:0] sy_i,
  input  logic [XW-1:0] sw_i,
  input  logic [YW-1:0] sh_i,
  output region_t       region_o,
  output logic          bg_hit_o
);

  int unsigned bg_lines, pic_lines, px, py, rx, ry;
  logic        pic_hit, main_hit, sub_hit;

  always_comb begin
    bg_lines  = std_i ? BG_LINES_625  : BG_LINES_525;
    pic_lines = std_i ? PIC_LINES_625 : PIC_LINES_525;
    px        = 32'(x_i);
    py        = 32'(y_i);
    bg_hit_o  = in_span(px, 32'(bgx_i), BG_W) && in_span(py, 32'(bgy_i), bg_lines);
    // Offsets from the background origin; only meaningful inside it.
    rx        = px - 32'(bgx_i);
    ry        = py - 32'(bgy_i);
    pic_hit   = bg_hit_o && (rx < PIC_W) && (ry < pic_lines);
    main_hit  = pic_hit && in_span(rx, 32'(mx_i), 32'(mw_i))
                        && in_span(ry, 32'(my_i), 32'(mh_i));
    sub_hit   = pic_hit && in_span(rx, 32'(sx_i), 32'(sw_i))
                        && in_span(ry, 32'(sy_i), 32'(sh_i));
    if (sub_hit)       region_o = RG_SUB;
    else if (main_hit) region_o = RG_MAIN;
    else if (bg_hit_o) region_o = RG_BG;
    else               region_o = RG_OUT;
  end

endmodule

// File: rtl/pipwin_timing.sv
module pipwin_timing
  import pipwin_pkg::*;
#(
  parameter int unsigned LINE_PIX      = 896,
  parameter int unsigned BG_W          = 768,
  parameter int unsigned PIC_W         = 720,
  parameter int unsigned BG_LINES_525  = 238,
  parameter int unsigned BG_LINES_625  = 286,
  parameter int unsigned PIC_LINES_525 = 228,
  parameter int unsigned PIC_LINES_625 = 276,
  parameter int unsigned YW            = 10,
  localparam int unsigned XW           = $clog2(LINE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          std625_i,
  input  logic [XW-1:0] bg_x_i,
  input  logic [YW-1:0] bg_y_i,
  input  logic [XW-1:0] main_x_i,
  input  logic [YW-1:0] main_y_i,
  input  logic [XW-1:0] main_w_i,
  input  logic [YW-1:0] main_h_i,
  input  logic [XW-1:0] sub_x_i,
  input  logic [YW-1:0] sub_y_i,
  input  logic [XW-1:0] sub_w_i,
  input  logic [YW-1:0] sub_h_i,
  output logic [1:0]    region_o,
  output logic          fblank_o,
  output logic          main_rd_o,
  output logic          sub_rd_o
);

  localparam int unsigned CFG_W  = 1 + XW + YW + 2 * (2 * XW + 2 * YW);
  localparam int unsigned LOOK_N = 2;

  logic [XW-1:0]    x;
  logic [YW-1:0]    y;
  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic             frame_start;

  logic          s_std;
  logic [XW-1:0] s_bgx, s_mx, s_mw, s_sx, s_sw;
  logic [YW-1:0] s_bgy, s_my, s_mh, s_sy, s_sh;

  region_t reg_k [LOOK_N];
  logic    bg_k  [LOOK_N];
  logic    look_ok;

  assign frame_start = hsync_i & vsync_i;

  pipwin_raster #(.LINE_PIX(LINE_PIX), .XW(XW), .YW(YW)) u_raster (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .x_o     (x),
    .y_o     (y)
  );

  assign cfg_d = {std625_i, bg_x_i, bg_y_i,
                  main_x_i, main_y_i, main_w_i, main_h_i,
                  sub_x_i, sub_y_i, sub_w_i, sub_h_i};

  pipwin_shadow #(.W(CFG_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (frame_start),
    .d_i    (cfg_d),
    .q_o    (cfg_q)
  );

  assign {s_std, s_bgx, s_bgy, s_mx, s_my, s_mw, s_mh,
          s_sx, s_sy, s_sw, s_sh} = cfg_q;

  // Decoder 0 classifies the current pixel, decoder 1 the next one.
  for (genvar k = 0; k < LOOK_N; k++) begin : g_look
    logic [XW:0] xk;
    assign xk = {1'b0, x} + (XW + 1)'(k);
    pipwin_decode #(
      .BG_W(BG_W), .PIC_W(PIC_W),
      .BG_LINES_525(BG_LINES_525), .BG_LINES_625(BG_LINES_625),
      .PIC_LINES_525(PIC_LINES_525), .PIC_LINES_625(PIC_LINES_625),
      .XW(XW), .YW(YW)
    ) u_dec (
      .x_i      (xk),
      .y_i      (y),
      .std_i    (s_std),
      .bgx_i    (s_bgx),
      .bgy_i    (s_bgy),
      .mx_i     (s_mx),
      .my_i     (s_my),
      .mw_i     (s_mw),
      .mh_i     (s_mh),
      .sx_i     (s_sx),
      .sy_i     (s_sy),
      .sw_i     (s_sw),
      .sh_i     (s_sh),
      .region_o (reg_k[k]),
      .bg_hit_o (bg_k[k])
    );
  end

  assign look_ok   = (x != XW'(LINE_PIX - 1));
  assign region_o  = reg_k[0];
  assign fblank_o  = bg_k[0];
  assign main_rd_o = look_ok && (reg_k[1] == RG_MAIN);
  assign sub_rd_o  = look_ok && (reg_k[1] == RG_SUB);

endmodule

// File: rtl/pipwin_checker.sv
module pipwin_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hsync_i,
  input logic       vsync_i,
  input logic [1:0] region_o,
  input logic       fblank_o,
  input logic       main_rd_o,
  input logic       sub_rd_o
);

  logic seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    seen_frame <= 1'b0;
    else if (hsync_i && vsync_i)   seen_frame <= 1'b1;
  end

  p_quiet_before_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_frame |-> (region_o == 2'd0 && !fblank_o && !main_rd_o && !sub_rd_o));

  p_fblank_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fblank_o == (region_o != 2'd0));

  p_req_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_rd_o && sub_rd_o));

  p_main_ahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (main_rd_o && !hsync_i) |=> (region_o == 2'd2));

  p_sub_ahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_rd_o && !hsync_i) |=> (region_o == 2'd3));

endmodule

bind pipwin_timing pipwin_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hsync_i   (hsync_i),
  .vsync_i   (vsync_i),
  .region_o  (region_o),
  .fblank_o  (fblank_o),
  .main_rd_o (main_rd_o),
  .sub_rd_o  (sub_rd_o)
);

// File: tb/sim_pipwin_timing.sv
`timescale 1ns/1ps
module sim_pipwin_timing;

  localparam int LP = 40, BW = 32, PW = 28;
  localparam int B5 = 12, B6 = 14, P5 = 10, P6 = 12;
  localparam int XW = 6, YW = 6, YMAX = 63;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, hs, vs, std;
  logic [XW-1:0] bgx, mx, mw, sx, sw;
  logic [YW-1:0] bgy, my, mh, sy, sh;
  logic [1:0] region;
  logic fblank, main_rd, sub_rd;

  pipwin_timing #(
    .LINE_PIX(LP), .BG_W(BW), .PIC_W(PW),
    .BG_LINES_525(B5), .BG_LINES_625(B6),
    .PIC_LINES_525(P5), .PIC_LINES_625(P6), .YW(YW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs), .std625_i(std),
    .bg_x_i(bgx), .bg_y_i(bgy),
    .main_x_i(mx), .main_y_i(my), .main_w_i(mw), .main_h_i(mh),
    .sub_x_i(sx), .sub_y_i(sy), .sub_w_i(sw), .sub_h_i(sh),
    .region_o(region), .fblank_o(fblank), .main_rd_o(main_rd), .sub_rd_o(sub_rd)
  );

  int checks = 0, fails = 0;
  int px = 0, py = YMAX;
  int seen = 0;
  int s_std = 0, s_bgx = 0, s_bgy = 0, s_mx = 0, s_my = 0, s_mw = 0, s_mh = 0;
  int s_sx = 0, s_sy = 0, s_sw = 0, s_sh = 0;

  function automatic int exp_region(int x, int y);
    int bl, pl, rx, ry;
    bit pic, m, s;
    bl = s_std ? B6 : B5;
    pl = s_std ? P6 : P5;
    if (!(x >= s_bgx && x < s_bgx + BW && y >= s_bgy && y < s_bgy + bl)) return 0;
    rx  = x - s_bgx;
    ry  = y - s_bgy;
    pic = (rx < PW) && (ry < pl);
    m   = pic && rx >= s_mx && rx < s_mx + s_mw && ry >= s_my && ry < s_my + s_mh;
    s   = pic && rx >= s_sx && rx < s_sx + s_sw && ry >= s_sy && ry < s_sy + s_sh;
    return s ? 3 : (m ? 2 : 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at x=%0d y=%0d: actual %0d expected %0d", tag, px, py, act, exp);
    end
  endtask

  task automatic check_all();
    int er;
    er = exp_region(px, py);
    if (seen == 0) chk("R10 region before first frame", int'(region), er);
    else           chk("R1 R2 R3 R4 R5 R6 R9 region", int'(region), er);
    chk("R7 fast blank", int'(fblank), (er != 0) ? 1 : 0);
    chk("R8 main read", int'(main_rd),
        (px + 1 < LP && exp_region(px + 1, py) == 2) ? 1 : 0);
    chk("R8 sub read", int'(sub_rd),
        (px + 1 < LP && exp_region(px + 1, py) == 3) ? 1 : 0);
  endtask

  // One pixel clock: drive strobes, mirror the raster at the edge, check at negedge.
  task automatic step(input logic h, input logic v);
    hs = h;
    vs = v;
    @(posedge clk);
    if (h) begin
      px = 0;
      if (v) begin
        py = 0; seen = 1;
        s_std = int'(std); s_bgx = int'(bgx); s_bgy = int'(bgy);
        s_mx = int'(mx); s_my = int'(my); s_mw = int'(mw); s_mh = int'(mh);
        s_sx = int'(sx); s_sy = int'(sy); s_sw = int'(sw); s_sh = int'(sh);
      end else if (py < YMAX) py++;
    end else if (px == LP - 1) begin
      px = 0;
      if (py < YMAX) py++;
    end else px++;
    @(negedge clk);
    check_all();
  endtask

  task automatic apply_cfg(int idx);
    case (idx)
      0: begin std=0; bgx=3;  bgy=2; mx=2;  my=1; mw=10; mh=5;  sx=8;  sy=3; sw=6;  sh=4;  end
      1: begin std=1; bgx=6;  bgy=1; mx=20; my=8; mw=20; mh=10; sx=0;  sy=0; sw=1;  sh=1;  end
      2: begin std=0; bgx=0;  bgy=5; mx=0;  my=0; mw=5;  mh=3;  sx=26; sy=9; sw=10; sh=10; end
      3: begin std=1; bgx=20; bgy=0; mx=15; my=0; mw=10; mh=2;  sx=5;  sy=2; sw=3;  sh=3;  end
      4: begin std=0; bgx=8;  bgy=3; mx=0;  my=0; mw=28; mh=10; sx=0;  sy=0; sw=0;  sh=0;  end
      default: begin std=1; bgx=1; bgy=0; mx=4; my=4; mw=4; mh=4; sx=4; sy=4; sw=4; sh=4; end
    endcase
  endtask

  // A frame whose settings for the following frame are applied mid-frame (R9).
  task automatic frame(int lines, int len, int nxt);
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < len; p++) begin
        if (l == 2 && p == 0) apply_cfg(nxt);
        if (p == 0)                 step(1'b1, (l == 0) ? 1'b1 : 1'b0);
        else if (l == 5 && p == 10) step(1'b0, 1'b1);   // R2: lone vsync ignored
        else                        step(1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    std = 0; bgx = '0; bgy = '0; mx = '0; my = '0; mw = '0; mh = '0;
    sx = '0; sy = '0; sw = '0; sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all();                              // R10 reset state
    apply_cfg(0);
    for (int i = 0; i < 60; i++) step(1'b0, (i == 7) ? 1'b1 : 1'b0); // R10, R2, R1 wrap
    frame(18, LP, 1);
    frame(18, LP, 2);
    frame(20, LP, 3);
    frame(18, LP, 4);
    frame(18, LP, 5);
    frame(16, 25, 0);                         // R1 early line restart
    step(1'b1, 1'b1);                         // R1 free-running wrap
    for (int i = 0; i < 4 * LP; i++) step(1'b0, 1'b0);
    frame(18, LP, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule